// File: doc/BRIEF.md
# Low-Power Mode and Clock Controller

This block governs the power modes and clock enables of a small microcontroller. It runs on one reference clock. Every clock it produces is a registered clock-enable for logic in that same domain, so no clock is ever gated directly. It drives an enable for each of three oscillators: internal, high-speed and low-speed. It picks which oscillator sources the system clock. It derives a geared CPU clock-enable, and it provides a peripheral clock-enable that software can stop.

The CPU asks for a low-power mode through two request strobes, one for halt and one for sleep. Halt stops only the CPU clock; everything else keeps its state. Sleep has two forms, chosen by two RTC control inputs. Full sleep turns every oscillator off. RTC-retained sleep keeps the low-speed oscillator running. Each mode accepts its own set of wake sources. After a sleep, the CPU clock stays gated until the selected source oscillator reports that it is ready.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While `rst` is high, `pwr_mode` is 0 (run), `osc_en` is 3'b001 (only the internal oscillator enabled), and `cpu_clk_en` and `periph_clk_en` are 0.
- R2: A `sleep_req` in run mode, with `rtc_run_en` low or `rtc_halt` high, enters full sleep (`pwr_mode` = 2). There all of `osc_en`, `periph_clk_en` and `cpu_clk_en` are 0.
- R3: Full sleep is left only on `wake_port`. `wake_rtc` and `wake_periph` leave the mode at 2 and the oscillators off.
- R4: A `sleep_req` in run mode, with `rtc_run_en` high and `rtc_halt` low, enters RTC-retained sleep (`pwr_mode` = 3). There `osc_en` is 3'b100: only the low-speed oscillator (bit 2) stays on.
- R5: RTC-retained sleep is left on `wake_rtc` or `wake_port`. `wake_periph` leaves it in mode 3.
- R6: A `halt_req` in run mode enters halt (`pwr_mode` = 1). There `cpu_clk_en` is 0, `periph_clk_en` keeps running, and `osc_en` holds its value even if `osc_off_req` changes.
- R7: Halt returns to run (`pwr_mode` = 0) on `wake_port` or `wake_periph`, and the CPU clock-enable resumes.
- R8: In run mode, `cpu_clk_en` pulses once every 1, 2, 4 or 8 reference cycles for `gear_sel` codes 0, 1, 2 and 3.
- R9: A new `gear_sel` value takes effect only when the current divided period completes. No pulse appears early.
- R10: `src_sel` codes 0, 1 and 2 select the internal (bit 0), high-speed (bit 1) and low-speed (bit 2) oscillator; code 3 selects the internal one. Outside sleep and halt, `osc_en[i]` is the inverse of `osc_off_req[i]`, except that the selected source stays enabled whatever its off request says.
- R11: Outside sleep, `periph_clk_en` is 1 in run and halt when `periph_stop` is low, and 0 when `periph_stop` is high.
- R12: A wake from either sleep enters the wake state (`pwr_mode` = 4). `cpu_clk_en` stays 0 until `osc_ready` for the selected source is high; the mode then returns to 0.
- R13: When `sleep_req` and `halt_req` arrive together in run mode, sleep wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep request strobe from the CPU |
| halt_req | input | 1 | Halt request strobe from the CPU |
| rtc_run_en | input | 1 | RTC clock-enable control bit |
| rtc_halt | input | 1 | RTC stop control bit |
| src_sel | input | 2 | System clock source select |
| osc_off_req | input | 3 | Per-oscillator disable request from software |
| gear_sel | input | 2 | CPU clock gear code |
| periph_stop | input | 1 | Stops the peripheral clock-enable |
| wake_port | input | 1 | Port interrupt |
| wake_rtc | input | 1 | RTC interrupt |
| wake_periph | input | 1 | Interrupt from a running peripheral |
| osc_ready | input | 3 | Per-oscillator ready flags |
| osc_en | output | 3 | Oscillator enables |
| cpu_clk_en | output | 1 | Geared CPU clock-enable pulse |
| periph_clk_en | output | 1 | Peripheral clock-enable |
| pwr_mode | output | 3 | Mode: 0 run, 1 halt, 2 full sleep, 3 RTC sleep, 4 wake |

## Verification
The hardest situation to reach is the wake state held open by a source oscillator that is not yet ready. Getting there takes a full sleep, a stray RTC and peripheral interrupt that must be ignored, and then a port wake while `osc_ready` is still low. The bench drops `osc_ready` before the wake and holds it low for several cycles, confirming that the mode stays at 4 with no CPU pulses, then raises it and watches the pulses resume. The gear boundary is reached by locking onto an observed slow-gear pulse and switching the gear mid-period.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [2:0] {
    MODE_RUN      = 3'd0,
    MODE_HALT     = 3'd1,
    MODE_SLP_FULL = 3'd2,
    MODE_SLP_RTC  = 3'd3,
    MODE_WAKE     = 3'd4
  } pcc_mode_e;

  localparam int OSC_N     = 3;
  localparam int OSC_INT   = 0;
  localparam int OSC_HS    = 1;
  localparam int OSC_LS    = 2;
  localparam int SRC_W     = 2;

  // Source code 3 is reserved and falls back to the internal oscillator.
  function automatic logic [SRC_W-1:0] src_index(input logic [SRC_W-1:0] sel);
    return (sel == SRC_W'(3)) ? SRC_W'(OSC_INT) : sel;
  endfunction

endpackage

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
  import pcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sleep_req,
  input  logic      halt_req,
  input  logic      rtc_run_en,
  input  logic      rtc_halt,
  input  logic      wake_port,
  input  logic      wake_rtc,
  input  logic      wake_periph,
  input  logic      src_ready,
  output pcc_mode_e mode_q
);

  pcc_mode_e mode_d;
  logic      keep_ls;

  assign keep_ls = rtc_run_en & ~rtc_halt;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (sleep_req)      mode_d = keep_ls ? MODE_SLP_RTC : MODE_SLP_FULL;
        else if (halt_req)  mode_d = MODE_HALT;
      end
      MODE_HALT:     if (wake_port | wake_periph) mode_d = MODE_RUN;
      MODE_SLP_FULL: if (wake_port)               mode_d = MODE_WAKE;
      MODE_SLP_RTC:  if (wake_port | wake_rtc)    mode_d = MODE_WAKE;
      MODE_WAKE:     if (src_ready)               mode_d = MODE_RUN;
      default:                                    mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RUN;
    else     mode_q <= mode_d;
  end

  // R3: full sleep ignores every wake source except the port
  a_r3_full_port_only: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SLP_FULL && !wake_port) |=> (mode_q == MODE_SLP_FULL));

  // R5: RTC sleep is not left on a peripheral interrupt alone
  a_r5_rtc_sleep_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SLP_RTC && !wake_port && !wake_rtc) |=> (mode_q == MODE_SLP_RTC));

  // R12: wake state persists until the source reports ready
  a_r12_wait_ready: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_WAKE && !src_ready) |=> (mode_q == MODE_WAKE));

  // R13: a sleep request from run never lands in halt
  a_r13_sleep_wins: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && sleep_req) |=> (mode_q != MODE_HALT));

endmodule

// File: rtl/pcc_osc_gate.sv
module pcc_osc_gate
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  pcc_mode_e        mode_i,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [OSC_N-1:0] osc_off_req,
  output logic [OSC_N-1:0] osc_en_q
);

  logic [SRC_W-1:0] src_idx;
  logic [OSC_N-1:0] run_en;
  logic [OSC_N-1:0] en_d;

  assign src_idx = src_index(src_sel);

  for (genvar g = 0; g < OSC_N; g++) begin : g_osc
    localparam logic [SRC_W-1:0] GIDX = SRC_W'(g);
    localparam logic             IS_LS = (g == OSC_LS);
    // The active source can never be switched off by software.
    assign run_en[g] = (src_idx == GIDX) | ~osc_off_req[g];
  end

  always_comb begin
    unique case (mode_i)
      MODE_SLP_FULL: en_d = '0;
      MODE_SLP_RTC:  en_d = OSC_N'(1) << OSC_LS;
      MODE_HALT:     en_d = osc_en_q;
      default:       en_d = run_en;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) osc_en_q <= OSC_N'(1) << OSC_INT;
    else     osc_en_q <= en_d;
  end

  // R2: one cycle into full sleep every oscillator is off
  a_r2_all_dark: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_SLP_FULL) |=> (osc_en_q == '0));

  // R10: the selected source is enabled while running
  a_r10_src_alive: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RUN) |=> osc_en_q[$past(src_idx)]);

  // R6: halt freezes the oscillator enables
  a_r6_halt_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_HALT && $past(mode_i) == MODE_HALT) |-> $stable(osc_en_q));

endmodule

// File: rtl/pcc_gear_div.sv
module pcc_gear_div #(
  parameter int GEAR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [GEAR_W-1:0] gear_sel,
  output logic              cpu_en_q
);

  localparam int CNT_W = (1 << GEAR_W) - 1;

  logic [GEAR_W-1:0] gear_act;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim;
  logic              tick;

  // Terminal count is 2**gear_act - 1: the low gear_act bits set.
  always_comb begin
    lim = '0;
    for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(gear_act));
  end

  assign tick = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      gear_act <= '0;
      cpu_en_q <= 1'b0;
    end else if (!run_i) begin
      cnt      <= '0;
      gear_act <= gear_sel;
      cpu_en_q <= 1'b0;
    end else if (tick) begin
      cnt      <= '0;
      gear_act <= gear_sel;
      cpu_en_q <= 1'b1;
    end else begin
      cnt      <= cnt + CNT_W'(1);
      cpu_en_q <= 1'b0;
    end
  end

  // R8: no CPU pulse while not running
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !cpu_en_q);

  // R9: the active gear changes only when a period closes
  a_r9_gear_boundary: assert property (@(posedge clk) disable iff (rst)
    (run_i && $past(run_i) && !$stable(gear_act)) |-> cpu_en_q);

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int GEAR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              halt_req,
  input  logic              rtc_run_en,
  input  logic              rtc_halt,
  input  logic [1:0]        src_sel,
  input  logic [2:0]        osc_off_req,
  input  logic [GEAR_W-1:0] gear_sel,
  input  logic              periph_stop,
  input  logic              wake_port,
  input  logic              wake_rtc,
  input  logic              wake_periph,
  input  logic [2:0]        osc_ready,
  output logic [2:0]        osc_en,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic [2:0]        pwr_mode
);

  pcc_mode_e mode_q;
  logic      src_ready;
  logic      periph_q;

  assign src_ready = osc_ready[src_index(src_sel)];

  pcc_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sleep_req   (sleep_req),
    .halt_req    (halt_req),
    .rtc_run_en  (rtc_run_en),
    .rtc_halt    (rtc_halt),
    .wake_port   (wake_port),
    .wake_rtc    (wake_rtc),
    .wake_periph (wake_periph),
    .src_ready   (src_ready),
    .mode_q      (mode_q)
  );

  pcc_osc_gate u_osc (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_q),
    .src_sel     (src_sel),
    .osc_off_req (osc_off_req),
    .osc_en_q    (osc_en)
  );

  pcc_gear_div #(.GEAR_W(GEAR_W)) u_gear (
    .clk      (clk),
    .rst      (rst),
    .run_i    (mode_q == MODE_RUN),
    .gear_sel (gear_sel),
    .cpu_en_q (cpu_clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) periph_q <= 1'b0;
    else     periph_q <= ~periph_stop & ((mode_q == MODE_RUN) | (mode_q == MODE_HALT));
  end

  assign periph_clk_en = periph_q;
  assign pwr_mode      = mode_q;

  // R11: the peripheral clock is dark during either sleep
  a_r11_periph_dark: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SLP_FULL || mode_q == MODE_SLP_RTC) |=> !periph_clk_en);

endmodule

// File: tb/pwr_clk_ctrl_tb_top.sv
module pwr_clk_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       sleep_req, halt_req, rtc_run_en, rtc_halt;
  logic [1:0] src_sel, gear_sel;
  logic [2:0] osc_off_req, osc_ready;
  logic       periph_stop, wake_port, wake_rtc, wake_periph;
  logic [2:0] osc_en, pwr_mode;
  logic       cpu_clk_en, periph_clk_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwr_clk_ctrl dut_i (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .halt_req(halt_req),
    .rtc_run_en(rtc_run_en), .rtc_halt(rtc_halt), .src_sel(src_sel),
    .osc_off_req(osc_off_req), .gear_sel(gear_sel), .periph_stop(periph_stop),
    .wake_port(wake_port), .wake_rtc(wake_rtc), .wake_periph(wake_periph),
    .osc_ready(osc_ready), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .pwr_mode(pwr_mode)
  );

  // {gear, src, off_req, periph_stop, exp_osc_en, exp_periph, exp_pulses_in_16}
  localparam logic [16:0] VECS [0:5] = '{
    {2'd0, 2'd0, 3'b000, 1'b0, 3'b111, 1'b1, 5'd16},
    {2'd1, 2'd1, 3'b111, 1'b0, 3'b010, 1'b1, 5'd8},
    {2'd2, 2'd2, 3'b011, 1'b1, 3'b100, 1'b0, 5'd4},
    {2'd3, 2'd0, 3'b110, 1'b0, 3'b001, 1'b1, 5'd2},
    {2'd1, 2'd3, 3'b101, 1'b1, 3'b011, 1'b0, 5'd8},
    {2'd0, 2'd1, 3'b000, 1'b0, 3'b111, 1'b1, 5'd16}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cpu_clk_en) c++;
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    tick(1);
    sig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c;
    int hit;
    rst = 1'b1; sleep_req = 0; halt_req = 0; rtc_run_en = 0; rtc_halt = 0;
    src_sel = 0; gear_sel = 0; osc_off_req = 0; osc_ready = 3'b111;
    periph_stop = 0; wake_port = 0; wake_rtc = 0; wake_periph = 0;
    tick(4);
    // R1 reset values
    check("R1 mode", pwr_mode, 0);
    check("R1 osc_en", osc_en, 3'b001);
    check("R1 cpu_clk_en", cpu_clk_en, 0);
    check("R1 periph_clk_en", periph_clk_en, 0);
    rst = 1'b0;

    // R8 R10 R11 vector walk
    for (int v = 0; v < 6; v++) begin
      gear_sel    = VECS[v][16:15];
      src_sel     = VECS[v][14:13];
      osc_off_req = VECS[v][12:10];
      periph_stop = VECS[v][9];
      tick(12);
      check("R10 osc_en", osc_en, VECS[v][8:6]);
      check("R11 periph_clk_en", periph_clk_en, VECS[v][5]);
      count_pulses(16, c);
      check("R8 cpu pulses", c, VECS[v][4:0]);
    end

    // R9 gear change lands on the period boundary
    src_sel = 0; osc_off_req = 3'b010; periph_stop = 0; gear_sel = 2'd3;
    tick(20);
    hit = 0;
    for (int i = 0; i < 20 && !hit; i++) begin
      @(negedge clk);
      if (cpu_clk_en) hit = 1;
    end
    tick(2);
    gear_sel = 2'd0;
    count_pulses(5, c);
    check("R9 no early pulse", c, 0);
    count_pulses(4, c);
    check("R9 new gear after boundary", c, 4);

    // R6 halt
    pulse(halt_req);
    tick(3);
    check("R6 mode", pwr_mode, 1);
    osc_off_req = 3'b000;
    count_pulses(8, c);
    check("R6 cpu stopped", c, 0);
    check("R6 osc_en held", osc_en, 3'b101);
    check("R6 periph running", periph_clk_en, 1);
    pulse(wake_rtc);
    tick(2);
    check("R7 rtc does not end halt", pwr_mode, 1);
    // R7 exit by peripheral interrupt
    pulse(wake_periph);
    tick(2);
    check("R7 mode run", pwr_mode, 0);
    count_pulses(8, c);
    check("R7 cpu resumes", c, 8);
    // R7 exit by port
    pulse(halt_req);
    tick(2);
    pulse(wake_port);
    tick(2);
    check("R7 port exit", pwr_mode, 0);

    // R2 full sleep, R3 wake filtering, R12 wait for ready
    rtc_run_en = 0; rtc_halt = 0;
    pulse(sleep_req);
    tick(3);
    check("R2 mode", pwr_mode, 2);
    check("R2 osc off", osc_en, 0);
    check("R2 periph off", periph_clk_en, 0);
    check("R2 cpu off", cpu_clk_en, 0);
    osc_ready = 3'b000;
    pulse(wake_rtc);
    pulse(wake_periph);
    tick(2);
    check("R3 mode stays", pwr_mode, 2);
    check("R3 osc stays off", osc_en, 0);
    pulse(wake_port);
    tick(1);
    check("R12 wake state", pwr_mode, 4);
    count_pulses(6, c);
    check("R12 cpu gated", c, 0);
    check("R12 still waiting", pwr_mode, 4);
    osc_ready = 3'b001;
    tick(2);
    check("R12 back to run", pwr_mode, 0);
    count_pulses(6, c);
    check("R12 cpu resumes", c, 6);
    osc_ready = 3'b111;

    // R2 with RTC enabled but stopped is still full sleep
    rtc_run_en = 1; rtc_halt = 1;
    pulse(sleep_req);
    tick(3);
    check("R2 rtc stopped mode", pwr_mode, 2);
    check("R2 rtc stopped osc", osc_en, 0);
    pulse(wake_port);
    tick(3);
    check("R12 fast ready run", pwr_mode, 0);

    // R4 R5 RTC-retained sleep
    rtc_halt = 0;
    pulse(sleep_req);
    tick(3);
    check("R4 mode", pwr_mode, 3);
    check("R4 only low-speed osc", osc_en, 3'b100);
    pulse(wake_periph);
    tick(2);
    check("R5 periph ignored", pwr_mode, 3);
    pulse(wake_rtc);
    tick(3);
    check("R5 rtc wake to run", pwr_mode, 0);
    pulse(sleep_req);
    tick(2);
    pulse(wake_port);
    tick(3);
    check("R5 port wake to run", pwr_mode, 0);

    // R13 simultaneous requests
    sleep_req = 1; halt_req = 1;
    tick(1);
    sleep_req = 0; halt_req = 0;
    tick(1);
    check("R13 sleep wins", pwr_mode, 3);
    pulse(wake_port);
    tick(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule